// File: doc/BRIEF.md
# Page-Table Next-Line Prefetch Generator

This block sits next to a second-level address-translation cache. It watches the outcome of each lookup in that cache and decides whether to prefetch the next line of last-level page-table entries. A lookup can cause a prefetch only when the entry for the 2 MB level was found in the cache. The last-level part of the lookup must also have missed, or must have hit an entry that an earlier prefetch brought in. The prefetch target is always the line that follows the one holding the current last-level entry. It stays inside the 4 KB page-table frame that the 2 MB-level entry points to, so a prefetch only ever reads last-level entries and never starts a multi-level walk.

Candidates are screened against a short history of recently issued line addresses. A candidate that passes is held in a single pending slot and offered on a valid/ready output. When the consumer stalls, a newer candidate overwrites the one waiting. A flush empties both the slot and the history.

A line address is the frame PPN concatenated with the line index inside the frame: `{frame_ppn, line}`. The default settings give 512 entries per frame and 8 entries per line, which is 64 lines per frame and a 6-bit line index.

Top module: `ptw_nl_prefetch`

## Requirements
- R1: While reset is asserted and after it is released, `pf_valid_o` is low until a qualifying lookup arrives.
- R2: A lookup with `lookup_valid_i`=1, `mid_hit_i`=1, `leaf_hit_i`=0 and line index L less than the last index makes `pf_valid_o` high on the next cycle, with `pf_line_o` = {`frame_ppn_i`, L+1}.
- R3: A lookup with `leaf_hit_i`=1 triggers a prefetch only when `leaf_from_pf_i`=1. A hit on an entry that no prefetch filled produces nothing.
- R4: A lookup with `mid_hit_i`=0 never triggers a prefetch.
- R5: When L is the last line of the frame (all ones), the candidate is dropped. An issued `pf_line_o` never carries a line index of 0.
- R6: A candidate whose line address matches one of the last FILT_DEPTH accepted line addresses (default 4) is dropped. The history replaces its oldest entry first, so once an address has been evicted it can be issued again.
- R7: While `pf_valid_o`=1 and `pf_ready_i`=0, with no new accepted candidate and no flush, `pf_valid_o` stays high and `pf_line_o` stays stable.
- R8: A new accepted candidate replaces a pending one, so at most one prefetch is ever pending.
- R9: A handshake (`pf_valid_o` and `pf_ready_i` both high at a clock edge) with no new candidate drops `pf_valid_o` on the next cycle.
- R10: `flush_i`=1 clears the pending prefetch and the history on the next edge. A candidate arriving in the same cycle is ignored and is not recorded.
- R11: While `lookup_valid_i`=0 the other lookup inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Clears the pending prefetch and the history |
| lookup_valid_i | input | 1 | A lookup outcome is presented this cycle |
| mid_hit_i | input | 1 | The 2 MB-level entry was found |
| leaf_hit_i | input | 1 | The last-level entry was found |
| leaf_from_pf_i | input | 1 | The last-level entry that hit was filled by a prefetch |
| frame_ppn_i | input | PPN_W | PPN of the last-level page-table frame |
| leaf_line_i | input | LINE_W | Line index of the looked-up entry within the frame |
| pf_valid_o | output | 1 | A prefetch request is offered |
| pf_ready_i | input | 1 | The consumer accepts the request |
| pf_line_o | output | PPN_W+LINE_W | Line address to prefetch, {ppn, line} |

## Verification
The bench aims at the frame edge. A design that wrapped the next-line index would prefetch line 0 of the same frame, or would spill into a neighbouring frame. It checks that a history entry becomes eligible again after four newer ones, since off-by-one eviction either suppresses good prefetches forever or lets duplicates through. It checks that a flush arriving together with a candidate leaves both the slot and the history empty, which catches designs that give the candidate priority or record it anyway. Under stalls it checks replacement and holding, because losing the newest candidate or dropping valid before a handshake would show as a wrong line or a missing request.

// File: rtl/ptw_pf_pkg.sv
package ptw_pf_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_MISS   = 2'd1,
    CAUSE_PF_HIT = 2'd2
  } pf_cause_e;
endpackage

// File: rtl/ptw_pf_trigger.sv
module ptw_pf_trigger
  import ptw_pf_pkg::*;
#(
  parameter int PPN_W  = 20,
  parameter int LINE_W = 6
) (
  input  logic                    lookup_valid_i,
  input  logic                    mid_hit_i,
  input  logic                    leaf_hit_i,
  input  logic                    leaf_from_pf_i,
  input  logic [PPN_W-1:0]        frame_ppn_i,
  input  logic [LINE_W-1:0]       leaf_line_i,
  output logic                    cand_v_o,
  output logic [PPN_W+LINE_W-1:0] cand_line_o
);
  pf_cause_e cause;
  logic      at_frame_end;

  always_comb begin
    if (!lookup_valid_i || !mid_hit_i) cause = CAUSE_NONE;
    else if (!leaf_hit_i)              cause = CAUSE_MISS;
    else if (leaf_from_pf_i)           cause = CAUSE_PF_HIT;
    else                               cause = CAUSE_NONE;
  end

  // next line would leave the frame the 2 MB entry points to
  assign at_frame_end = &leaf_line_i;
  assign cand_v_o     = (cause != CAUSE_NONE) && !at_frame_end;
  assign cand_line_o  = {frame_ppn_i, leaf_line_i + LINE_W'(1)};
endmodule

// File: rtl/ptw_pf_filter.sv
module ptw_pf_filter #(
  parameter int LA_W  = 26,
  parameter int DEPTH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic [LA_W-1:0] probe_i,
  input  logic            ins_i,
  output logic            hit_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LA_W-1:0]  tag_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] hit_vec;
  logic [PTR_W-1:0] ptr_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == probe_i);
  end
  assign hit_o = |hit_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (ins_i) begin
      vld_q[ptr_q] <= 1'b1;
      ptr_q <= (ptr_q == PTR_W'(DEPTH-1)) ? '0 : ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (ins_i && !flush_i) tag_q[ptr_q] <= probe_i;
  end

  // R6: history never holds the same line twice
  a_r6_unique_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  a_r6_no_dup_insert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |-> !hit_o);
endmodule

// File: rtl/ptw_pf_slot.sv
module ptw_pf_slot #(
  parameter int LA_W = 26
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            load_i,
  input  logic [LA_W-1:0] line_i,
  input  logic            ready_i,
  output logic            valid_o,
  output logic [LA_W-1:0] line_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      line_o  <= '0;
    end else if (flush_i) begin
      valid_o <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      line_o  <= line_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !load_i && !flush_i) |=> (valid_o && $stable(line_o)));
  a_r9_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && !load_i && !flush_i) |=> !valid_o);
  a_r10_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !valid_o);
  a_r8_replace: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !flush_i) |=> (valid_o && line_o == $past(line_i)));
endmodule

// File: rtl/ptw_nl_prefetch.sv
module ptw_nl_prefetch #(
  parameter int PPN_W             = 20,
  parameter int ENTRIES_PER_FRAME = 512,
  parameter int ENTRIES_PER_LINE  = 8,
  parameter int FILT_DEPTH        = 4,
  localparam int LINE_W = $clog2(ENTRIES_PER_FRAME / ENTRIES_PER_LINE),
  localparam int LA_W   = PPN_W + LINE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              lookup_valid_i,
  input  logic              mid_hit_i,
  input  logic              leaf_hit_i,
  input  logic              leaf_from_pf_i,
  input  logic [PPN_W-1:0]  frame_ppn_i,
  input  logic [LINE_W-1:0] leaf_line_i,
  output logic              pf_valid_o,
  input  logic              pf_ready_i,
  output logic [LA_W-1:0]   pf_line_o
);
  logic            cand_v, filt_hit, load;
  logic [LA_W-1:0] cand_line;

  ptw_pf_trigger #(.PPN_W(PPN_W), .LINE_W(LINE_W)) u_trig (
    .lookup_valid_i (lookup_valid_i),
    .mid_hit_i      (mid_hit_i),
    .leaf_hit_i     (leaf_hit_i),
    .leaf_from_pf_i (leaf_from_pf_i),
    .frame_ppn_i    (frame_ppn_i),
    .leaf_line_i    (leaf_line_i),
    .cand_v_o       (cand_v),
    .cand_line_o    (cand_line)
  );

  assign load = cand_v && !filt_hit && !flush_i;

  ptw_pf_filter #(.LA_W(LA_W), .DEPTH(FILT_DEPTH)) u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .probe_i (cand_line),
    .ins_i   (load),
    .hit_o   (filt_hit)
  );

  ptw_pf_slot #(.LA_W(LA_W)) u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .load_i  (load),
    .line_i  (cand_line),
    .ready_i (pf_ready_i),
    .valid_o (pf_valid_o),
    .line_o  (pf_line_o)
  );

  a_r5_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_o |-> (pf_line_o[LINE_W-1:0] != '0));
  a_r4_mid_needed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pf_valid_o) |-> $past(lookup_valid_i && mid_hit_i));
  a_r3_trigger_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pf_valid_o) |-> $past(!leaf_hit_i || leaf_from_pf_i));
endmodule

// File: tb/ptw_nl_prefetch_test.sv
module ptw_nl_prefetch_test;
  localparam int PPN_W = 20;
  localparam int LINE_W = 6;
  localparam int LA_W = PPN_W + LINE_W;
  localparam int FD = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic flush, lv, mid, lh, lpf, rdy;
  logic [PPN_W-1:0] ppn;
  logic [LINE_W-1:0] line;
  logic pf_valid_o;
  logic [LA_W-1:0] pf_line_o;

  int n_chk = 0, n_fail = 0;
  string cur_tag = "R1";

  logic m_v = 1'b0;
  logic [LA_W-1:0] m_line = '0;
  logic [LA_W-1:0] m_f [FD];
  logic [FD-1:0] m_fv = '0;
  int m_ptr = 0;

  localparam logic [PPN_W-1:0] PA = 20'h12345;

  always #4 clk = ~clk;

  ptw_nl_prefetch uut (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush), .lookup_valid_i(lv),
    .mid_hit_i(mid), .leaf_hit_i(lh), .leaf_from_pf_i(lpf),
    .frame_ppn_i(ppn), .leaf_line_i(line), .pf_valid_o(pf_valid_o),
    .pf_ready_i(rdy), .pf_line_o(pf_line_o)
  );

  task automatic chk(input string tag, input logic ev, input logic [LA_W-1:0] el);
    n_chk++;
    if (pf_valid_o !== ev || (ev && pf_line_o !== el)) begin
      n_fail++;
      $display("FAIL %s: valid=%b line=%h expected valid=%b line=%h",
               tag, pf_valid_o, pf_line_o, ev, el);
    end
  endtask

  task automatic step();
    logic cand, dup;
    logic [LA_W-1:0] nl;
    cand = lv && mid && (!lh || lpf) && (line != '1);
    nl = {ppn, line + LINE_W'(1)};
    dup = 1'b0;
    for (int i = 0; i < FD; i++) if (m_fv[i] && m_f[i] == nl) dup = 1'b1;
    @(posedge clk);
    if (flush) begin
      m_v = 1'b0; m_fv = '0; m_ptr = 0;
    end else if (cand && !dup) begin
      m_v = 1'b1; m_line = nl; m_f[m_ptr] = nl; m_fv[m_ptr] = 1'b1;
      m_ptr = (m_ptr + 1) % FD;
    end else if (m_v && rdy) begin
      m_v = 1'b0;
    end
    #1;
    chk(cur_tag, m_v, m_line);
    @(negedge clk);
  endtask

  task automatic idle(input logic r);
    lv = 0; mid = 0; lh = 0; lpf = 0; flush = 0; rdy = r;
    step();
  endtask

  // kind: 0 miss, 1 hit on prefetched entry, 2 plain hit
  task automatic look(input int kind, input logic mh, input logic [LINE_W-1:0] ln,
                      input logic r);
    lv = 1; mid = mh; lh = (kind != 0); lpf = (kind == 1); ppn = PA;
    line = ln; rdy = r; flush = 0;
    step();
  endtask

  function automatic logic [LA_W-1:0] la(input logic [LINE_W-1:0] l);
    return {PA, l};
  endfunction

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: valid=%b line=%h expected valid=0 line=0", pf_valid_o, pf_line_o);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    flush = 0; lv = 0; mid = 0; lh = 0; lpf = 0; rdy = 0; ppn = PA; line = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 1'b0, '0);
    rst_ni = 1'b1;
    cur_tag = "R1"; idle(0); chk("R1 after reset", 1'b0, '0);

    cur_tag = "R2"; look(0, 1, 6'd2, 0); chk("R2 miss", 1'b1, la(6'd3));
    cur_tag = "R7"; idle(0); idle(0); chk("R7 hold", 1'b1, la(6'd3));
    cur_tag = "R9"; idle(1); chk("R9 drain", 1'b0, '0);
    cur_tag = "R3"; look(1, 1, 6'd10, 1); chk("R3 pf hit", 1'b1, la(6'd11));
    idle(1);
    look(2, 1, 6'd20, 1); chk("R3 plain hit", 1'b0, '0);
    cur_tag = "R4"; look(0, 0, 6'd30, 1); chk("R4 no mid", 1'b0, '0);
    cur_tag = "R11";
    lv = 0; mid = 1; lh = 0; lpf = 0; line = 6'd31; rdy = 1; flush = 0; step();
    chk("R11 no lookup", 1'b0, '0);
    cur_tag = "R5"; look(0, 1, 6'd63, 1); chk("R5 frame end", 1'b0, '0);
    look(0, 1, 6'd62, 1); chk("R5 last line", 1'b1, la(6'd63));
    idle(1);
    cur_tag = "R6"; look(0, 1, 6'd2, 1); chk("R6 dup", 1'b0, '0);
    look(0, 1, 6'd40, 1); idle(1);
    look(0, 1, 6'd50, 1); idle(1);
    look(0, 1, 6'd2, 1); chk("R6 evicted", 1'b1, la(6'd3));
    idle(1);
    cur_tag = "R8"; look(0, 1, 6'd5, 0); look(0, 1, 6'd7, 0);
    chk("R8 replace", 1'b1, la(6'd8));
    idle(1);
    cur_tag = "R10"; look(0, 1, 6'd12, 0);
    lv = 1; mid = 1; lh = 0; lpf = 0; line = 6'd14; rdy = 0; flush = 1; step();
    chk("R10 flush", 1'b0, '0);
    look(0, 1, 6'd12, 1); chk("R10 history cleared", 1'b1, la(6'd13));
    look(0, 1, 6'd14, 1); chk("R10 candidate not recorded", 1'b1, la(6'd15));
    idle(1);

    cur_tag = "R2 random";
    for (int i = 0; i < 4000; i++) begin
      lv = ($urandom % 4) != 0;
      mid = ($urandom % 5) != 0;
      lh = $urandom % 2;
      lpf = $urandom % 2;
      ppn = ($urandom % 2) ? PA : 20'h0ABCD;
      line = ($urandom % 4 == 0) ? 6'd63 : LINE_W'($urandom % 12);
      rdy = ($urandom % 3) != 0;
      flush = ($urandom % 50) == 0;
      step();
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule